// File: doc/BRIEF.md
# UART Receive FIFO with Interrupt Status

This block holds characters coming out of a UART deserializer until a host collects them. Each byte presented on the write side goes into a circular store. A host pops bytes by reading the data register through a simple read/write strobe port. The store keeps a write pointer and an occupancy count. The slot to read is the write pointer minus the count, wrapped to the depth.

The level flags are pure functions of the current occupancy and a programmable trigger level. They are recomputed every cycle and never stored. These flags are empty, full, trigger reached, and a transmit-empty flag that is always 1. Each cycle they are OR-ed into a sticky interrupt status register. A byte that arrives while the store is full is dropped, and this sets a sticky overflow bit in the same register. The host clears bits by writing 1 to them. An interrupt mask selects which sticky bits drive the single interrupt line. The depth must be a power of two.

Register map (3-bit address, 8-bit data): 0 = receive data (a read pops), 1 = level status (read-only), 2 = sticky interrupt status (write 1 to clear), 3 = interrupt mask (read/write, resets to 0), 4 = trigger level (read/write, resets to 32).

Top module: `uart_rx_fifo_irq`

## Requirements
- R1: Bytes read from address 0 come out in the order they were pushed. A push raises the occupancy by one and a pop lowers it by one. The occupancy never exceeds the depth (64).
- R2: Status bit 1 (empty) is 1 exactly when the occupancy is zero. Coming out of reset, the status register reads 0x0A.
- R3: Status bit 2 (full) is 1 exactly when the occupancy equals the depth.
- R4: Status bit 0 (trigger) is 1 whenever the occupancy is greater than or equal to the trigger register at address 4, which resets to 32.
- R5: Status bit 3 (transmit empty) always reads 1.
- R6: Every cycle, status bits 3..0 are OR-ed into the interrupt status register at address 2. Those bits stay set after their condition goes away. Writing 1 to a bit clears it, but if the condition still holds, the set wins.
- R7: A push while the store is full and no pop is taking place drops the byte. The occupancy is left unchanged, and bit 4 (overflow) of the interrupt status register is set.
- R8: A read of address 0 while the store is empty returns 0 and leaves the occupancy at zero.
- R9: The irq output is 1 exactly when the bitwise AND of the mask register (address 3, reset 0) and the interrupt status register is nonzero.
- R10: A push and a pop in the same cycle on a non-empty store (full included) keep the occupancy unchanged and do not flag overflow.
- R11: A write to the status register (address 1) has no effect on what it reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte from the deserializer is present this cycle |
| rx_data | input | 8 | Received byte |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (a read of address 0 pops) |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for the addressed register, combinational |
| irq | output | 1 | Masked interrupt output |

## Verification
The assertions assume two things about the inputs. First, each strobe is held for exactly one clock. Second, a pop and a push may coincide, so the occupancy properties treat that pairing as a separate case instead of assuming that the two never overlap. The stimulus changes every input half a cycle away from the capturing edge and drops each strobe after one edge. It reaches the full and empty boundaries only through ordered push and pop sequences, so the assertions on occupancy and the sticky bits always see legal strobe patterns.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int          REG_AW = 3;
    localparam logic [2:0]  ADR_DATA = 3'd0;
    localparam logic [2:0]  ADR_STAT = 3'd1;
    localparam logic [2:0]  ADR_ISR  = 3'd2;
    localparam logic [2:0]  ADR_IMR  = 3'd3;
    localparam logic [2:0]  ADR_TRIG = 3'd4;
    localparam int BIT_TRIG  = 0;
    localparam int BIT_EMPTY = 1;
    localparam int BIT_FULL  = 2;
    localparam int BIT_TXE   = 3;
    localparam int BIT_OVR   = 4;
    localparam logic [7:0] LVL_TO_ISR = 8'h0F;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] level,
    output logic          overflow
);
    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [CW-1:0] cnt;
    } st_t;

    st_t           s_d, s_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic          is_full, is_empty, take, give;
    logic [PW-1:0] rptr;

    always_comb begin
        is_full  = (s_q.cnt == CW'(DEPTH));
        is_empty = (s_q.cnt == '0);
        give     = pop && !is_empty;
        take     = push && (!is_full || give);
        rptr     = s_q.wptr - PW'(s_q.cnt);
        overflow = push && is_full && !give;
        pop_data = is_empty ? '0 : mem_q[rptr];
        s_d      = s_q;
        if (take) s_d.wptr = s_q.wptr + 1'b1;
        case ({take, give})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (take) mem_q[s_q.wptr] <= push_data;
    end

    assign level = s_q.cnt;

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));
    // R7
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && is_full && !pop) |=> $stable(s_q.cnt));
    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && is_empty && !push) |=> (s_q.cnt == '0));
    // R10
    pushpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !is_empty) |=> $stable(s_q.cnt));
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
    import rxq_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int RW       = 8,
    parameter int TRIG_RST = 32,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     level,
    input  logic              overflow,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [RW-1:0]     wr_data,
    output logic [RW-1:0]     status,
    output logic [RW-1:0]     isr,
    output logic [RW-1:0]     imr,
    output logic [RW-1:0]     trig,
    output logic              irq
);
    typedef struct packed {
        logic [RW-1:0] isr;
        logic [RW-1:0] imr;
        logic [RW-1:0] trig;
    } st_t;

    st_t           s_d, s_q;
    logic [RW-1:0] clr, ovr_set, lvl_ext;

    always_comb begin
        lvl_ext              = RW'(level);
        status               = '0;
        status[BIT_TRIG]     = (lvl_ext >= s_q.trig);
        status[BIT_EMPTY]    = (level == '0);
        status[BIT_FULL]     = (level == CW'(DEPTH));
        status[BIT_TXE]      = 1'b1;
        clr                  = (wr_en && wr_addr == ADR_ISR) ? wr_data : '0;
        ovr_set              = '0;
        ovr_set[BIT_OVR]     = overflow;
        s_d                  = s_q;
        s_d.isr = (s_q.isr & ~clr) | (status & RW'(LVL_TO_ISR)) | ovr_set;
        if (wr_en && wr_addr == ADR_IMR)  s_d.imr  = wr_data;
        if (wr_en && wr_addr == ADR_TRIG) s_d.trig = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.isr  <= '0;
            s_q.imr  <= '0;
            s_q.trig <= RW'(TRIG_RST);
        end else begin
            s_q <= s_d;
        end
    end

    assign isr  = s_q.isr;
    assign imr  = s_q.imr;
    assign trig = s_q.trig;
    assign irq  = |(s_q.isr & s_q.imr);

    // R6
    isr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADR_ISR) |=> ((s_q.isr & $past(s_q.isr)) == $past(s_q.isr)));
    // R7
    ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> s_q.isr[BIT_OVR]);
endmodule

// File: rtl/uart_rx_fifo_irq.sv
module uart_rx_fifo_irq
    import rxq_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int DW       = 8,
    parameter int TRIG_RST = 32,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DW-1:0]     rx_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq
);
    logic          pop, ovf;
    logic [DW-1:0] pop_data, status, isr, imr, trig;
    logic [CW-1:0] level;

    assign pop = reg_rd && (reg_addr == ADR_DATA);

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .push(rx_valid), .push_data(rx_data),
        .pop(pop), .pop_data(pop_data), .level(level), .overflow(ovf)
    );

    rxq_irq #(.DEPTH(DEPTH), .RW(DW), .TRIG_RST(TRIG_RST)) u_irq (
        .clk(clk), .rst_n(rst_n), .level(level), .overflow(ovf),
        .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .status(status), .isr(isr), .imr(imr), .trig(trig), .irq(irq)
    );

    always_comb begin
        case (reg_addr)
            ADR_DATA: reg_rdata = pop_data;
            ADR_STAT: reg_rdata = status;
            ADR_ISR:  reg_rdata = isr;
            ADR_IMR:  reg_rdata = imr;
            ADR_TRIG: reg_rdata = trig;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: tb/sim_uart_rx_fifo_irq.sv
module sim_uart_rx_fifo_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_rx_fifo_irq u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(posedge clk); #1 rx_valid = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic push_pop(input logic [7:0] b, output logic [7:0] v);
        @(negedge clk); rx_valid = 1'b1; rx_data = b; reg_rd = 1'b1; reg_addr = 3'd0;
        #1 v = reg_rdata;
        @(posedge clk); #1 begin rx_valid = 1'b0; reg_rd = 1'b0; end
    endtask

    function automatic logic [7:0] lvl(input int n, input int t);
        return {4'b0, 1'b1, n == 64, n == 0, n >= t};
    endfunction

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R2 R5 reset state
        rd(3'd1, v); chk("R2 reset status", v, 8'h0A);
        rd(3'd4, v); chk("R4 trigger reset", v, 8'd32);
        rd(3'd3, v); chk("R9 mask reset", v, 8'h00);
        chk("R9 irq at reset", {7'b0, irq}, 8'h00);
        rd(3'd2, v); chk("R6 isr after reset", v, 8'h0A);
        // R6 set wins while condition holds
        wr(3'd2, 8'hFF);
        rd(3'd2, v); chk("R6 set wins", v, 8'h0A);
        // R6 sticky then cleared
        push(8'hA5);
        rd(3'd1, v); chk("R2 nonempty status", v, 8'h08);
        rd(3'd2, v); chk("R6 sticky empty", v, 8'h0A);
        wr(3'd2, 8'h02);
        rd(3'd2, v); chk("R6 w1c", v, 8'h08);
        rd(3'd0, v); chk("R1 single byte", v, 8'hA5);
        // R3 R4 fill sweep with trigger 5
        wr(3'd4, 8'd5);
        for (int i = 0; i < 64; i++) begin
            push(pat(i));
            rd(3'd1, v); chk("R3/R4 fill level", v, lvl(i + 1, 5));
        end
        // R7 overflow
        push(8'hEE);
        rd(3'd1, v); chk("R7 still full", v, lvl(64, 5));
        rd(3'd2, v); chk("R7 overflow flag", v & 8'h10, 8'h10);
        // R9 masking
        wr(3'd3, 8'h10);
        @(negedge clk); chk("R9 irq masked on", {7'b0, irq}, 8'h01);
        wr(3'd2, 8'h10);
        @(negedge clk); chk("R9 irq after clear", {7'b0, irq}, 8'h00);
        // R10 push+pop at full
        push_pop(8'h77, v); chk("R10 oldest byte", v, pat(0));
        rd(3'd1, v); chk("R10 still full", v, lvl(64, 5));
        rd(3'd2, v); chk("R10 no overflow", v & 8'h10, 8'h00);
        // R1 drain in order
        for (int i = 1; i < 64; i++) begin
            rd(3'd0, v); chk("R1 order", v, pat(i));
            rd(3'd1, v); chk("R2/R4 drain level", v, lvl(64 - i, 5));
        end
        rd(3'd0, v); chk("R1 last byte", v, 8'h77);
        rd(3'd1, v); chk("R2 empty after drain", v, lvl(0, 5));
        // R8 pop when empty
        rd(3'd0, v); chk("R8 empty read", v, 8'h00);
        rd(3'd1, v); chk("R8 still empty", v, 8'h0A);
        push(8'h55);
        rd(3'd0, v); chk("R8 count unchanged", v, 8'h55);
        rd(3'd1, v); chk("R8 empty again", v, 8'h0A);
        // R10 push+pop on empty: pop returns 0, byte stored
        push_pop(8'h3C, v); chk("R10 empty pair read", v, 8'h00);
        rd(3'd0, v); chk("R10 empty pair stored", v, 8'h3C);
        // R11 status write ignored
        wr(3'd1, 8'hFF);
        rd(3'd1, v); chk("R11 status write", v, 8'h0A);
        // R4 trigger 0 on empty
        wr(3'd4, 8'd0);
        rd(3'd1, v); chk("R4 trigger zero", v, 8'h0B);
        // R9 mask selects trigger bit
        wr(3'd3, 8'h01);
        @(negedge clk); chk("R9 irq trig bit", {7'b0, irq}, 8'h01);
        wr(3'd3, 8'h00);
        @(negedge clk); chk("R9 irq mask off", {7'b0, irq}, 8'h00);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule